// File: doc/BRIEF.md
# Multi-Bit Table-Driven Pattern Recognizer

This block is a finite-state recognizer whose whole behaviour lives in a writable lookup table. Each epoch it takes one symbol of `SYM_W` bits from an upstream serial-to-parallel assembler. It joins that symbol with the present-state code to form a table address and performs one table read. The word it reads holds the next-state code and one output code for each of the `SYM_W` bits consumed. One lookup therefore advances the machine by `SYM_W` input bits. The logic can run at a fraction of the line bit rate while still reporting a result for every single bit.

A host loads the table through a synchronous write port while the recognizer is idle. Any pattern set can be monitored by building the table from a single-bit Mealy machine. For each state and each combination of `SYM_W` bits, the bits are applied one at a time in arrival order. The final state becomes the next-state field, and the per-bit outputs become the output lanes. The default build has a 4-bit state code, 2-bit symbols and 1-bit output codes, which gives 64 table words of 6 bits.

Top module: `mbit_table_recognizer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `state_code` is 0. Reset leaves the table contents unchanged.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `sym_valid` high.
- R3: An epoch with `sym_valid` high reads the word at address `{state_code, sym_data}`, with the state code in the upper `STATE_W` bits. In the next cycle `state_code` equals bits `[WORD_W-1 -: STATE_W]` of that word, and `out_tuple` equals its low `SYM_W*OUT_W` bits.
- R4: In a cycle with `sym_valid` low, `state_code` does not change and no result is produced.
- R5: Lane order: `sym_data[SYM_W-1]` is the earliest bit of the epoch. The output lane `out_tuple[SYM_W*OUT_W-1 -: OUT_W]` belongs to that earliest bit, and lane 0 belongs to the latest bit. A table built from a single-bit machine reports, bit for bit, the same output that machine gives on the serial stream, including overlapping matches.
- R6: A cycle with `tbl_wr_en` high stores `tbl_wr_data` at `tbl_wr_addr`. Later lookups of that address return the stored word.
- R7: When a lookup and a table write hit the same address in the same cycle, the lookup returns the word held before the write. The new word is seen from the next lookup on.
- R8: With the 00000/00110 table, a lane reads 1 exactly when its bit completes one of those sequences. Reloading the table with a table built for 11 makes lanes report 11 completions instead, with no change to the logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Epoch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | An input symbol is present this epoch |
| sym_data | input | SYM_W | Input symbol; the MSB is the earliest bit |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | STATE_W+SYM_W | Table write address |
| tbl_wr_data | input | STATE_W+SYM_W*OUT_W | Table word: next-state code in the MSBs, output lanes in the LSBs |
| out_valid | output | 1 | `out_tuple` and `state_code` reflect a new lookup |
| out_tuple | output | SYM_W*OUT_W | One output code per consumed bit |
| state_code | output | STATE_W | Present-state code |

## Verification
A table write and a lookup can occur in the same cycle. The bench provokes this by writing a new word to address `{0, 00}` in the exact cycle that a lookup from the reset state reads that address. It expects the old output lanes and the old next state (state 2) in that result. After a reset, a second lookup of the same address must return the freshly written word (lanes 11, state 9). All other traffic is judged by a scoreboard that is fed from a serial shift-history model of the patterns. That model is independent of the table, and it is used on random streams with idle gaps.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  // Bits needed to code k distinct output values, at least one.
  function automatic int unsigned code_width(input int unsigned k);
    int unsigned w;
    w = 1;
    while ((1 << w) < k) w++;
    return w;
  endfunction

  // Address width of a table indexed by state code and symbol.
  function automatic int unsigned table_addr_width(input int unsigned state_w,
                                                   input int unsigned sym_w);
    return state_w + sym_w;
  endfunction

  // Word width: next-state code plus one output code per symbol bit.
  function automatic int unsigned table_word_width(input int unsigned state_w,
                                                   input int unsigned sym_w,
                                                   input int unsigned out_w);
    return state_w + sym_w * out_w;
  endfunction

endpackage

// File: rtl/mtr_addr_join.sv
module mtr_addr_join #(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned SYM_W   = 2,
  localparam int unsigned ADDR_W = STATE_W + SYM_W
) (
  input  logic [STATE_W-1:0] state_in,
  input  logic [SYM_W-1:0]   sym_in,
  output logic [ADDR_W-1:0]  addr_out
);

  // The present state occupies the high part and the symbol the low part.
  always_comb begin
    addr_out = '0;
    addr_out[ADDR_W-1 -: STATE_W] = state_in;
    addr_out[SYM_W-1:0]           = sym_in;
  end

endmodule

// File: rtl/mtr_table_ram.sv
module mtr_table_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 6,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] peek_word,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem [DEPTH];

  // The word held at the read address before any write of this cycle.
  assign peek_word = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // The registered read samples the pre-write contents (read-first).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word <= '0;
    end else if (rd_en) begin
      rd_word <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/mtr_epoch_stage.sv
module mtr_epoch_stage #(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned SYM_W   = 2,
  parameter int unsigned OUT_W   = 1,
  localparam int unsigned LANES_W = SYM_W * OUT_W,
  localparam int unsigned WORD_W  = STATE_W + LANES_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [WORD_W-1:0]  word,
  output logic [STATE_W-1:0] state_code,
  output logic [LANES_W-1:0] out_tuple,
  output logic               out_valid
);

  logic [OUT_W-1:0] lane_code [SYM_W];

  // The next-state field is the feedback path into the address.
  assign state_code = word[WORD_W-1 -: STATE_W];

  // Lane k carries the output of the bit that arrived (SYM_W-1-k) places
  // after the earliest bit of the epoch.
  for (genvar k = 0; k < SYM_W; k++) begin : g_lane
    assign lane_code[k] = word[k*OUT_W +: OUT_W];
    assign out_tuple[k*OUT_W +: OUT_W] = lane_code[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= fire;
  end

endmodule

// File: rtl/mbit_table_recognizer.sv
module mbit_table_recognizer #(
  parameter int unsigned SYM_W    = 2,
  parameter int unsigned STATE_W  = 4,
  parameter int unsigned NUM_OUTS = 2,
  localparam int unsigned OUT_W   = mtr_pkg::code_width(NUM_OUTS),
  localparam int unsigned LANES_W = SYM_W * OUT_W,
  localparam int unsigned ADDR_W  = mtr_pkg::table_addr_width(STATE_W, SYM_W),
  localparam int unsigned WORD_W  = mtr_pkg::table_word_width(STATE_W, SYM_W, OUT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sym_valid,
  input  logic [SYM_W-1:0]   sym_data,
  input  logic               tbl_wr_en,
  input  logic [ADDR_W-1:0]  tbl_wr_addr,
  input  logic [WORD_W-1:0]  tbl_wr_data,
  output logic               out_valid,
  output logic [LANES_W-1:0] out_tuple,
  output logic [STATE_W-1:0] state_code
);

  // Named internal events, used by the bound checker.
  logic [ADDR_W-1:0] lookup_addr;
  logic [WORD_W-1:0] lookup_word;
  logic [WORD_W-1:0] held_word;
  logic              lookup_fire;

  assign lookup_fire = sym_valid;

  mtr_addr_join #(
    .STATE_W (STATE_W),
    .SYM_W   (SYM_W)
  ) u_join (
    .state_in (state_code),
    .sym_in   (sym_data),
    .addr_out (lookup_addr)
  );

  mtr_table_ram #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_wr_en),
    .wr_addr   (tbl_wr_addr),
    .wr_data   (tbl_wr_data),
    .rd_en     (lookup_fire),
    .rd_addr   (lookup_addr),
    .peek_word (lookup_word),
    .rd_word   (held_word)
  );

  mtr_epoch_stage #(
    .STATE_W (STATE_W),
    .SYM_W   (SYM_W),
    .OUT_W   (OUT_W)
  ) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (lookup_fire),
    .word       (held_word),
    .state_code (state_code),
    .out_tuple  (out_tuple),
    .out_valid  (out_valid)
  );

endmodule

// File: rtl/mtr_checker.sv
module mtr_checker #(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned SYM_W   = 2,
  parameter int unsigned OUT_W   = 1,
  localparam int unsigned LANES_W = SYM_W * OUT_W,
  localparam int unsigned ADDR_W  = STATE_W + SYM_W,
  localparam int unsigned WORD_W  = STATE_W + LANES_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sym_valid,
  input logic               tbl_wr_en,
  input logic [ADDR_W-1:0]  tbl_wr_addr,
  input logic [WORD_W-1:0]  tbl_wr_data,
  input logic               out_valid,
  input logic [LANES_W-1:0] out_tuple,
  input logic [STATE_W-1:0] state_code,
  input logic [ADDR_W-1:0]  lookup_addr,
  input logic [WORD_W-1:0]  lookup_word
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && state_code == '0));

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> out_valid);

  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> !out_valid);

  // R3
  lookup_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> ({state_code, out_tuple} == $past(lookup_word)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(state_code));

  // R7
  collide_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && tbl_wr_en && tbl_wr_addr == lookup_addr &&
     tbl_wr_data != lookup_word)
    |=> ({state_code, out_tuple} != $past(tbl_wr_data)));

endmodule

bind mbit_table_recognizer mtr_checker #(
  .STATE_W (STATE_W),
  .SYM_W   (SYM_W),
  .OUT_W   (OUT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sym_valid   (sym_valid),
  .tbl_wr_en   (tbl_wr_en),
  .tbl_wr_addr (tbl_wr_addr),
  .tbl_wr_data (tbl_wr_data),
  .out_valid   (out_valid),
  .out_tuple   (out_tuple),
  .state_code  (state_code),
  .lookup_addr (lookup_addr),
  .lookup_word (lookup_word)
);

// File: tb/mbit_table_recognizer_bench.sv
module mbit_table_recognizer_bench;

  localparam int SYM_W  = 2;
  localparam int STATE_W = 4;
  localparam int OUT_W  = 1;
  localparam int LW     = SYM_W * OUT_W;
  localparam int AW     = STATE_W + SYM_W;
  localparam int WW     = STATE_W + LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic [SYM_W-1:0] sym_data = '0;
  logic tbl_wr_en = 1'b0;
  logic [AW-1:0] tbl_wr_addr = '0;
  logic [WW-1:0] tbl_wr_data = '0;
  logic out_valid;
  logic [LW-1:0] out_tuple;
  logic [STATE_W-1:0] state_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [LW-1:0] exp_q [$];
  string tag_q [$];

  logic [31:0] hist;
  int hcnt;
  bit pat_b;

  always #10 clk = ~clk;

  mbit_table_recognizer u_mbit_table_recognizer (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .out_valid(out_valid), .out_tuple(out_tuple), .state_code(state_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Single-bit machine for 00000 / 00110: returns {next state, output}.
  function automatic logic [4:0] step_a(input logic [3:0] s, input logic b);
    case (s)
      4'd0: return b ? {4'd0, 1'b0} : {4'd1, 1'b0};
      4'd1: return b ? {4'd0, 1'b0} : {4'd2, 1'b0};
      4'd2: return b ? {4'd5, 1'b0} : {4'd3, 1'b0};
      4'd3: return b ? {4'd5, 1'b0} : {4'd4, 1'b0};
      4'd4: return b ? {4'd5, 1'b0} : {4'd4, 1'b1};
      4'd5: return b ? {4'd6, 1'b0} : {4'd1, 1'b0};
      4'd6: return b ? {4'd0, 1'b0} : {4'd1, 1'b1};
      default: return 5'd0;
    endcase
  endfunction

  // Single-bit machine for 11.
  function automatic logic [4:0] step_b(input logic [3:0] s, input logic b);
    case (s)
      4'd0: return b ? {4'd1, 1'b0} : {4'd0, 1'b0};
      4'd1: return b ? {4'd1, 1'b1} : {4'd0, 1'b0};
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [WW-1:0] build_word(input bit use_b, input logic [AW-1:0] a);
    logic [4:0] r1, r2;
    r1 = use_b ? step_b(a[AW-1 -: STATE_W], a[1]) : step_a(a[AW-1 -: STATE_W], a[1]);
    r2 = use_b ? step_b(r1[4:1], a[0]) : step_a(r1[4:1], a[0]);
    return {r2[4:1], r1[0], r2[0]};
  endfunction

  // R6: table loaded through the write port while idle.
  task automatic load_table(input bit use_b);
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      tbl_wr_en = 1'b1;
      tbl_wr_addr = AW'(a);
      tbl_wr_data = build_word(use_b, AW'(a));
    end
    @(negedge clk);
    tbl_wr_en = 1'b0;
    pat_b = use_b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sym_valid = 1'b0;
    @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 0);
    chk("R1 state in reset", 32'(state_code), 0);
    rst_n = 1'b1;
    hist = 0;
    hcnt = 0;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 0);
    chk("R1 state after reset", 32'(state_code), 0);
  endtask

  // Serial reference: shift history, no use of the table.
  function automatic logic [LW-1:0] ref_epoch(input logic [SYM_W-1:0] s);
    logic [LW-1:0] e;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      hist = {hist[30:0], s[i]};
      hcnt++;
      if (pat_b) e[i] = (hcnt >= 2) && (hist[1:0] == 2'b11);
      else       e[i] = (hcnt >= 5) && (hist[4:0] == 5'b00000 || hist[4:0] == 5'b00110);
    end
    return e;
  endfunction

  task automatic epoch(input logic [SYM_W-1:0] s, input logic [LW-1:0] e, input string tag);
    @(negedge clk);
    sym_valid = 1'b1;
    sym_data = s;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected result", 32'(out_valid), 0);
      end else begin
        logic [LW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(out_tuple), 32'(e));
      end
    end
  end

  task automatic run_stream(input int n, input string tag);
    logic [STATE_W-1:0] st;
    for (int k = 0; k < n; k++) begin
      logic [SYM_W-1:0] s;
      s = SYM_W'($urandom_range(0, (1 << SYM_W) - 1));
      if ($urandom_range(0, 3) == 0) s = '0;
      epoch(s, ref_epoch(s), tag);
      if ($urandom_range(0, 15) == 0) begin
        idle();
        st = state_code;
        for (int g = 0; g < 3; g++) begin
          @(negedge clk);
          chk("R4 idle state hold", 32'(state_code), 32'(st));
          chk("R4 idle no result", 32'(out_valid), 0);
        end
      end
    end
    idle();
    @(negedge clk);
    chk("R2 scoreboard drained", 32'(exp_q.size()), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    hist = 0;
    hcnt = 0;
    pat_b = 1'b0;
    repeat (2) @(negedge clk);
    load_table(1'b0);
    do_reset();

    // R7: write address {0,00} in the same cycle it is looked up.
    @(negedge clk);
    sym_valid = 1'b1;
    sym_data = 2'b00;
    tbl_wr_en = 1'b1;
    tbl_wr_addr = '0;
    tbl_wr_data = {4'd9, 2'b11};
    exp_q.push_back(2'b00);
    tag_q.push_back("R7 old lanes on collision");
    @(negedge clk);
    sym_valid = 1'b0;
    tbl_wr_en = 1'b0;
    chk("R7 old next state on collision", 32'(state_code), 2);
    chk("R2 valid after lookup", 32'(out_valid), 1);
    do_reset();
    epoch(2'b00, 2'b11, "R7 new word seen next lookup");
    idle();
    chk("R3 next state from written word", 32'(state_code), 9);
    @(negedge clk);
    tbl_wr_en = 1'b1;
    tbl_wr_addr = '0;
    tbl_wr_data = build_word(1'b0, '0);
    @(negedge clk);
    tbl_wr_en = 1'b0;
    do_reset();

    // R3 / R5 directed: 00 00 0x completes 00000 on the earliest bit of epoch 3.
    epoch(2'b00, ref_epoch(2'b00), "R5 directed 00000");
    epoch(2'b00, ref_epoch(2'b00), "R5 directed 00000");
    epoch(2'b01, ref_epoch(2'b01), "R5 directed 00000 lane order");
    idle();
    chk("R3 state after 00000 then 1", 32'(state_code), 5);
    do_reset();

    // R5 / R8 overlapping random streams.
    run_stream(2000, "R5 R8 stream 00000/00110");

    // R8: reprogram, table survives reset.
    load_table(1'b1);
    do_reset();
    epoch(2'b11, ref_epoch(2'b11), "R8 directed 11 lanes");
    epoch(2'b11, ref_epoch(2'b11), "R8 directed 11 overlap");
    idle();
    run_stream(600, "R8 stream 11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule